// File: doc/BRIEF.md
# Configurable Memory Error Correction Datapath

This block guards a 16-bit memory data path. On the write side it computes six check bits from the outgoing word, and the memory stores those bits beside the data. On the read side it takes the stored word and its check bits and rebuilds the syndrome. It then returns a repaired word and reports whether the read was clean, repaired or beyond repair. A mode input selects the protection scheme. One scheme corrects single errors and detects double errors with a Hamming code plus an overall parity bit. The other uses a single even-parity bit, which detects errors but cannot correct them.

Encoding and decoding are purely combinational. The two error flags are registered at the clock edge that ends a read cycle, which is any edge with `rd_en` high. Two diagnostic registers support software. One holds the most recent word that needed repair. The other is a one-shot latch for the address of the first failing read, which ignores later failures until an explicit clear re-arms it.

Top module: `edac_core`

## Requirements
- R1: With `mode_par` low, the 16 data bits go, lowest first, into the codeword positions 1..21 that are not powers of two. `wr_chk[k]` (k=0..4) is the XOR of the data bits whose position has bit k set. `wr_chk[5]` is the XOR of all 16 data bits and `wr_chk[4:0]`.
- R2: With `mode_par` high, `wr_chk[0]` is the XOR of the 16 data bits and `wr_chk[5:1]` are zero.
- R3: With `mode_par` low, a read whose 22 stored bits contain exactly one flipped bit (data or check) presents the original data on `rd_fixed` in the same cycle.
- R4: With `mode_par` low, a single flipped bit, including one in a check bit, raises `err_corr` for one cycle after the edge that ends the read, and `err_uncorr` stays low.
- R5: With `mode_par` low, two flipped bits raise `err_uncorr` and leave `err_corr` low. `err_corr` and `err_uncorr` are never high together.
- R6: With `mode_par` high, a read raises `err_uncorr` exactly when `rd_chk[0]` differs from the XOR of `rd_data`. `rd_fixed` equals `rd_data`, `rd_chk[5:1]` are ignored, and `err_corr` never rises.
- R7: A clean read leaves both flags low, and an edge with `rd_en` low drops both flags.
- R8: `diag_data` is loaded with the repaired word on every read that raises `err_corr`. Every other edge leaves it unchanged.
- R9: While `fail_valid` is low, a read that raises either flag loads `rd_addr` into `fail_addr` and sets `fail_valid`. While `fail_valid` is high, later failures leave `fail_addr` unchanged.
- R10: `fail_clr` high at an edge clears `fail_valid`, and it wins over a capture at the same edge.
- R11: After reset, `err_corr`, `err_uncorr`, `fail_valid`, `fail_addr` and `diag_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_par | input | 1 | 1 selects parity mode, 0 selects correcting mode |
| wr_data | input | 16 | Word being written to memory |
| wr_chk | output | 6 | Check bits for `wr_data` |
| rd_en | input | 1 | High during a read cycle; the edge sampling it high ends the read |
| rd_addr | input | AW (20) | Address of the current read |
| rd_data | input | 16 | Data word read from memory |
| rd_chk | input | 6 | Check bits read from memory |
| rd_fixed | output | 16 | Repaired read data, combinational |
| err_corr | output | 1 | Registered: last read held a repaired single error |
| err_uncorr | output | 1 | Registered: last read held an error that cannot be repaired |
| diag_data | output | 16 | Last repaired word |
| fail_clr | input | 1 | Re-arms the first-failure latch |
| fail_valid | output | 1 | First-failure latch is holding an address |
| fail_addr | output | AW (20) | Address of the first failing read |

## Verification
The assertions assume that `rd_en`, `mode_par` and `fail_clr` are settled before each active edge and that the mode does not change within a read. The bench drives every input on the falling edge and holds it through the following rising edge, so this assumption holds. The assertions do not depend on how many bits are corrupted. Every stimulus word is either a fresh encoding from the bench or such an encoding with zero, one or two distinct bits flipped, so the bench can predict the outcome for every read. Triple errors are never applied, because the correcting code may misclassify them.

// File: rtl/edac_pkg.sv
package edac_pkg;
  localparam int unsigned EDAC_DW = 16;
  localparam int unsigned EDAC_HW = 5;
  localparam int unsigned EDAC_CW = EDAC_HW + 1;

  // Codeword position (1-based) of data bit j: skip powers of two
  function automatic logic [EDAC_HW-1:0] data_pos(input int unsigned j);
    int unsigned p;
    int unsigned n;
    p = 0;
    n = 0;
    for (int unsigned q = 1; q < 32; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (n == j) p = q;
        n++;
      end
    end
    return EDAC_HW'(p);
  endfunction

  function automatic logic [EDAC_HW-1:0] ham_bits(input logic [EDAC_DW-1:0] d);
    logic [EDAC_HW-1:0] h;
    logic [EDAC_HW-1:0] pos;
    h = '0;
    for (int unsigned j = 0; j < EDAC_DW; j++) begin
      pos = data_pos(j);
      for (int unsigned k = 0; k < EDAC_HW; k++)
        if (pos[k]) h[k] = h[k] ^ d[j];
    end
    return h;
  endfunction
endpackage

// File: rtl/edac_encode.sv
module edac_encode
  import edac_pkg::*;
(
  input  logic               mode_par,
  input  logic [EDAC_DW-1:0] data,
  output logic [EDAC_CW-1:0] chk
);
  logic [EDAC_HW-1:0] ham;

  always_comb begin
    ham = ham_bits(data);
    if (mode_par) chk = {{(EDAC_CW-1){1'b0}}, ^data};
    else          chk = {^{data, ham}, ham};
  end
endmodule

// File: rtl/edac_decode.sv
module edac_decode
  import edac_pkg::*;
(
  input  logic               mode_par,
  input  logic [EDAC_DW-1:0] data,
  input  logic [EDAC_CW-1:0] chk,
  output logic [EDAC_DW-1:0] fixed,
  output logic               single,
  output logic               uncorr
);
  logic [EDAC_HW-1:0] syn;
  logic               ovr;
  logic [EDAC_DW-1:0] flip;
  logic               hit_data;
  logic               hit_chk;

  always_comb begin
    syn = chk[EDAC_HW-1:0] ^ ham_bits(data);
    ovr = ^{data, chk};
    for (int unsigned j = 0; j < EDAC_DW; j++)
      flip[j] = (data_pos(j) == syn);
    hit_data = |flip;
    hit_chk  = (syn == '0) || $onehot(syn);
    if (mode_par) begin
      fixed  = data;
      single = 1'b0;
      uncorr = chk[0] ^ (^data);
    end else begin
      single = ovr && (hit_data || hit_chk);
      uncorr = ((syn != '0) && !ovr) || (ovr && !hit_data && !hit_chk);
      fixed  = (ovr && hit_data) ? (data ^ flip) : data;
    end
  end
endmodule

// File: rtl/edac_diag.sv
module edac_diag
  import edac_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic               ev_corr,
  input  logic               ev_uncorr,
  input  logic [AW-1:0]      rd_addr,
  input  logic [EDAC_DW-1:0] fixed,
  input  logic               fail_clr,
  output logic               err_corr,
  output logic               err_uncorr,
  output logic [EDAC_DW-1:0] diag_data,
  output logic               fail_valid,
  output logic [AW-1:0]      fail_addr
);
  logic any_err;
  assign any_err = rd_en && (ev_corr || ev_uncorr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_corr   <= 1'b0;
      err_uncorr <= 1'b0;
      diag_data  <= '0;
    end else begin
      err_corr   <= rd_en && ev_corr;
      err_uncorr <= rd_en && ev_uncorr;
      if (rd_en && ev_corr) diag_data <= fixed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_valid <= 1'b0;
      fail_addr  <= '0;
    end else if (fail_clr) begin
      fail_valid <= 1'b0;
    end else if (any_err && !fail_valid) begin
      fail_valid <= 1'b1;
      fail_addr  <= rd_addr;
    end
  end
endmodule

// File: rtl/edac_core.sv
module edac_core
  import edac_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_par,
  input  logic [15:0]   wr_data,
  output logic [5:0]    wr_chk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic [15:0]   rd_data,
  input  logic [5:0]    rd_chk,
  output logic [15:0]   rd_fixed,
  output logic          err_corr,
  output logic          err_uncorr,
  output logic [15:0]   diag_data,
  input  logic          fail_clr,
  output logic          fail_valid,
  output logic [AW-1:0] fail_addr
);
  logic ev_corr;
  logic ev_uncorr;

  edac_encode u_enc (
    .mode_par (mode_par),
    .data     (wr_data),
    .chk      (wr_chk)
  );

  edac_decode u_dec (
    .mode_par (mode_par),
    .data     (rd_data),
    .chk      (rd_chk),
    .fixed    (rd_fixed),
    .single   (ev_corr),
    .uncorr   (ev_uncorr)
  );

  edac_diag #(.AW(AW)) u_diag (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .ev_corr    (ev_corr),
    .ev_uncorr  (ev_uncorr),
    .rd_addr    (rd_addr),
    .fixed      (rd_fixed),
    .fail_clr   (fail_clr),
    .err_corr   (err_corr),
    .err_uncorr (err_uncorr),
    .diag_data  (diag_data),
    .fail_valid (fail_valid),
    .fail_addr  (fail_addr)
  );
endmodule

// File: rtl/edac_chk.sv
module edac_chk #(
  parameter int unsigned AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_par,
  input logic          rd_en,
  input logic          fail_clr,
  input logic [AW-1:0] rd_addr,
  input logic          ev_corr,
  input logic          ev_uncorr,
  input logic          err_corr,
  input logic          err_uncorr,
  input logic [15:0]   diag_data,
  input logic          fail_valid,
  input logic [AW-1:0] fail_addr
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_corr && err_uncorr)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!err_corr && !err_uncorr)); // R7
  AST_PARITY_NO_CORR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode_par) |=> !err_corr); // R6
  AST_DIAG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && ev_corr) |=> $stable(diag_data)); // R8
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_valid && !fail_clr) |=> (fail_valid && $stable(fail_addr))); // R9
  AST_FAIL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (ev_corr || ev_uncorr) && !fail_valid && !fail_clr)
      |=> (fail_valid && fail_addr == $past(rd_addr))); // R9
  AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fail_clr |=> !fail_valid); // R10
endmodule

bind edac_core edac_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_par   (mode_par),
  .rd_en      (rd_en),
  .fail_clr   (fail_clr),
  .rd_addr    (rd_addr),
  .ev_corr    (ev_corr),
  .ev_uncorr  (ev_uncorr),
  .err_corr   (err_corr),
  .err_uncorr (err_uncorr),
  .diag_data  (diag_data),
  .fail_valid (fail_valid),
  .fail_addr  (fail_addr)
);

// File: tb/sim_edac_core.sv
`timescale 1ns/1ps
module sim_edac_core;
  localparam int AW = 20;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_par = 1'b0;
  logic [15:0]   wr_data = '0;
  logic [5:0]    wr_chk;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data = '0;
  logic [5:0]    rd_chk = '0;
  logic [15:0]   rd_fixed;
  logic          err_corr, err_uncorr;
  logic [15:0]   diag_data;
  logic          fail_clr = 1'b0;
  logic          fail_valid;
  logic [AW-1:0] fail_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic          m_valid = 0;
  logic [AW-1:0] m_addr = '0;
  logic [15:0]   m_diag = '0;

  always #2.5 clk = ~clk;

  edac_core #(.AW(AW)) u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench encoder: build the codeword array explicitly
  function automatic logic [5:0] ref_enc(input logic [15:0] d, input bit par);
    logic [21:1] cw;
    logic [5:0] c;
    int idx;
    if (par) return {5'b0, ^d};
    idx = 0;
    cw = '0;
    for (int p = 1; p <= 21; p++)
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
        cw[p] = d[idx];
        idx++;
      end
    c = '0;
    for (int k = 0; k < 5; k++)
      for (int p = 1; p <= 21; p++)
        if ((p >> k) & 1) c[k] ^= cw[p];
    c[5] = ^{d, c[4:0]};
    return c;
  endfunction

  // One read: flip = XOR mask over {chk,data}; exp_c / exp_u predicted flags
  task automatic do_read(input logic [15:0] d, input bit par, input logic [21:0] flip,
                         input logic [AW-1:0] a, input bit exp_c, input bit exp_u,
                         input logic [15:0] exp_fix, input string tag);
    logic [21:0] w;
    w = {ref_enc(d, par), d} ^ flip;
    @(negedge clk);
    mode_par = par; rd_en = 1'b1; rd_addr = a;
    rd_data = w[15:0]; rd_chk = w[21:16];
    #1;
    check(rd_fixed == exp_fix, {tag, " data"}, 32'(rd_fixed), 32'(exp_fix));
    if (exp_c) m_diag = exp_fix;
    if ((exp_c || exp_u) && !m_valid) begin m_valid = 1; m_addr = a; end
    @(negedge clk);
    rd_en = 1'b0;
    check(err_corr == exp_c, {tag, " err_corr"}, 32'(err_corr), 32'(exp_c));
    check(err_uncorr == exp_u, {tag, " err_uncorr"}, 32'(err_uncorr), 32'(exp_u));
    check(diag_data == m_diag, "R8 diag_data", 32'(diag_data), 32'(m_diag));
    check(fail_valid == m_valid, "R9 fail_valid", 32'(fail_valid), 32'(m_valid));
    check(fail_addr == m_addr, "R9 fail_addr", 32'(fail_addr), 32'(m_addr));
  endtask

  function automatic logic [21:0] one_hot22(input int b);
    return 22'(1) << b;
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] d;
    int b1, b2;
    void'($urandom(32'd4242));
    #12; rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!err_corr && !err_uncorr, "R11 flags", {err_corr, err_uncorr}, 0);
    check(diag_data == 0 && fail_valid == 0 && fail_addr == 0, "R11 diag", 32'(diag_data), 0);

    // R1 / R2 encoder, directed then random
    for (int i = 0; i < 80; i++) begin
      d = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'($urandom());
      wr_data = d;
      mode_par = 1'b0; #1;
      check(wr_chk == ref_enc(d, 0), "R1 wr_chk", 32'(wr_chk), 32'(ref_enc(d, 0)));
      mode_par = 1'b1; #1;
      check(wr_chk == ref_enc(d, 1), "R2 wr_chk", 32'(wr_chk), 32'(ref_enc(d, 1)));
    end

    // R7 clean reads, both modes
    for (int i = 0; i < 10; i++) begin
      d = 16'($urandom());
      do_read(d, i[0], 22'h0, 20'($urandom()), 0, 0, d, "R7 clean");
    end

    // R3 / R4 every single-bit position, then random; R9 first capture
    for (int b = 0; b < 22; b++) begin
      d = 16'($urandom());
      do_read(d, 0, one_hot22(b), 20'(b + 16'h100), 1, 0, d, "R3 R4 single");
    end
    // R7 flags drop after idle edge
    @(negedge clk);
    check(!err_corr && !err_uncorr, "R7 idle", {err_corr, err_uncorr}, 0);

    // R5 double errors; R8 diag must hold
    for (int i = 0; i < 40; i++) begin
      d = 16'($urandom());
      b1 = int'($urandom_range(21, 0));
      b2 = (b1 + 1 + int'($urandom_range(20, 0))) % 22;
      do_read(d, 0, one_hot22(b1) | one_hot22(b2), 20'($urandom()), 0, 1, d ^ (one_hot22(b1) | one_hot22(b2)) >> 0, "R5 double");
    end

    // R10 clear, and clear wins over same-edge capture
    @(negedge clk); fail_clr = 1'b1; rd_en = 1'b1; mode_par = 1'b0;
    rd_data = 16'h1234; rd_chk = ref_enc(16'h1234, 0) ^ 6'h01; rd_addr = 20'hABCDE;
    @(negedge clk); fail_clr = 1'b0; rd_en = 1'b0;
    m_valid = 0; m_diag = 16'h1234;
    check(fail_valid == 0, "R10 clear wins", 32'(fail_valid), 0);
    do_read(16'h5A5A, 0, one_hot22(3), 20'h00777, 1, 0, 16'h5A5A, "R9 recapture");

    // R6 parity mode: data / chk[0] flips fail, chk[5:1] ignored
    for (int b = 0; b < 22; b++) begin
      d = 16'($urandom());
      if (b >= 17)
        do_read(d, 1, one_hot22(b), 20'(b), 0, 0, d, "R6 ignored");
      else
        do_read(d, 1, one_hot22(b), 20'(b), 0, 1, d ^ one_hot22(b) >> 0, "R6 parity");
    end

    // random mix
    for (int i = 0; i < 150; i++) begin
      d = 16'($urandom());
      b1 = int'($urandom_range(21, 0));
      if (i % 3 == 0) do_read(d, 0, 22'h0, 20'($urandom()), 0, 0, d, "R7 mix");
      else if (i % 3 == 1) do_read(d, 0, one_hot22(b1), 20'($urandom()), 1, 0, d, "R3 mix");
      else do_read(d, 1, one_hot22(b1 % 16), 20'($urandom()), 0, 1, d ^ 16'(one_hot22(b1 % 16)), "R6 mix");
    end

    done = 1;
    finish_run();
  end
endmodule